// File: doc/BRIEF.md
# Floating-point issue latency sequencer

This block times the issue and retirement of instructions for a floating-point engine that executes one instruction at a time. It performs no arithmetic. Each instruction arrives as a descriptor over a valid/ready handshake. The descriptor carries:

- an operation class and a precision bit;
- a two-bit class tag for each of three input operands, for the intermediate product and for the final result;
- a flush-to-zero bit;
- a hint that the data takes the short path.

From these fields the block works out how many cycles the instruction occupies the engine. It then holds busy for exactly that many cycles and pulses done on the last of them. It accepts nothing else until the instruction has retired.

The latency is the sum of several parts. The first part is a base figure picked by operation and precision, taken as the minimum of its range on the short path and the maximum otherwise. Subnormal penalties are added to that base: one per input operand, one for a subnormal intermediate and one for a subnormal result. All penalties are dropped when flush-to-zero is set. Any special input operand forces the minimum base figure with no penalty. The two decode cycles that separate consecutive instructions are already part of every figure. So an instruction of latency L accepted at one edge leaves the next instruction free to issue L edges later.

Top module: `fpu_issue_timer`

## Requirements
- R1: After reset, busy and done are 0, in_ready is 1 and lat_out is 0. in_ready is the inverse of busy at all times.
- R2: A descriptor accepted at a clock edge (in_valid and in_ready both 1) makes busy 1 for exactly L consecutive cycles. L is its latency. done is 1 only in the last of those cycles. in_ready returns to 1 in the cycle after done.
- R3: While busy is 1, in_valid is ignored. lat_out and the remaining busy duration do not change, and no descriptor presented during that time is executed afterwards.
- R4: Add/subtract (op 0) takes 9 cycles on the short path and 10 otherwise, in either precision, for normal operands.
- R5: For normal operands the short and long latencies are as follows. Op 1 (multiply): single 10 and 12, double 11 and 17. Op 2 (fused multiply-accumulate): single 18 and 21, double 19 and 26. Op 3 (divide): single 20 and 37, double 29 and 65. Op 4 (square root): single 19 and 33, double 29 and 60. The short-path hint (in_fast=1) selects the short latency.
- R6: Op 5 (abs/negate/copy/constant) takes 4 cycles. Op 6 (compare) takes 4 cycles with in_fast=1 and 7 otherwise. Op 7 (integer to float) takes 9. Op 8 (float to integer) takes 8. Op 9 (float to fixed) takes 6 single and 8 double. Op 10 (single to double) takes 5. Op 11 (double to single) takes 7. Codes 12 to 15 take 4.
- R7: With flush-to-zero off, each subnormal (class code 1) input operand that the operation reads adds 9 cycles on the short path and 10 otherwise. This applies only to ops 0 to 4 and 10. Ops 0, 1 and 3 read operands a and b. Op 2 reads a, b and c. Ops 4 and 10 read a only. Class tags of unread operands have no effect.
- R8: With flush-to-zero off, a subnormal result tag adds 6 cycles (short path) or 7 cycles to ops 0 to 3. On other ops the result tag has no effect.
- R9: With flush-to-zero off, a subnormal intermediate tag adds 11 cycles (short path) or 13 cycles to ops 2 and 11. On other ops the intermediate tag has no effect.
- R10: With in_ftz=1, no subnormal penalty applies and the latency equals the base figure of R4 to R6.
- R11: An operand tag with bit 1 set (special: zero, infinity, NaN) on any operand the operation reads forces the short-path base latency and removes every penalty. For ops 6 the operands read are a and b; for ops 5 and 7 to 11 it is a.
- R12: lat_out shows the latency L of the accepted descriptor from the cycle after acceptance until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Engine idle, descriptor can be accepted |
| in_op | input | 4 | Operation class code (see R4 to R6) |
| in_dbl | input | 1 | 1 for double precision |
| in_cls_a | input | 2 | Operand a class: 0 normal, 1 subnormal, 2 or 3 special |
| in_cls_b | input | 2 | Operand b class, same coding |
| in_cls_c | input | 2 | Operand c class, same coding |
| in_cls_mid | input | 2 | Intermediate value class, same coding |
| in_cls_res | input | 2 | Result class, same coding |
| in_ftz | input | 1 | Flush-to-zero mode, 1 disables penalties |
| in_fast | input | 1 | Short-path hint from the data |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle pulse on the last busy cycle |
| lat_out | output | 7 | Latency of the most recently accepted instruction |

## Verification
The latency path is combinational up to a single state register. busy and lat_out therefore change one edge after acceptance. done rises L-1 edges after that and falls together with busy one edge later. The bench drives at the falling edge and holds in_valid across exactly one rising edge. It then samples at every following falling edge: it first reads lat_out, then counts the cycles with busy high and records where done appears. The expected L of each scenario is written into the test as a constant worked out from the requirements. In the stall scenario the bench holds a conflicting descriptor on the inputs while the engine is busy. It checks that lat_out is unchanged and that busy falls after the original count and stays low.

// File: rtl/fpit_pkg.sv
package fpit_pkg;

    localparam int CNT_W  = 7;
    localparam int N_OPND = 3;

    // subnormal penalty figures, short path / long path
    localparam int PEN_OPND_LO = 9;
    localparam int PEN_OPND_HI = 10;
    localparam int PEN_MID_LO  = 11;
    localparam int PEN_MID_HI  = 13;
    localparam int PEN_RES_LO  = 6;
    localparam int PEN_RES_HI  = 7;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_MUL  = 4'd1,
        OP_MAC  = 4'd2,
        OP_DIV  = 4'd3,
        OP_SQRT = 4'd4,
        OP_MOVE = 4'd5,
        OP_CMP  = 4'd6,
        OP_I2F  = 4'd7,
        OP_F2I  = 4'd8,
        OP_F2X  = 4'd9,
        OP_S2D  = 4'd10,
        OP_D2S  = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        CLS_NORM = 2'd0,
        CLS_SUB  = 2'd1,
        CLS_SPEC = 2'd2,
        CLS_SPX  = 2'd3
    } cls_e;

    function automatic logic is_sub(input logic [1:0] c);
        return c == CLS_SUB;
    endfunction

    function automatic logic is_special(input logic [1:0] c);
        return c[1];
    endfunction

endpackage

// File: rtl/fpit_base_lat.sv
module fpit_base_lat
    import fpit_pkg::*;
#(
    parameter int LW = CNT_W
) (
    input  logic [3:0]    op,
    input  logic          dbl,
    output logic [LW-1:0] lat_lo,
    output logic [LW-1:0] lat_hi
);

    typedef struct packed {
        logic [LW-1:0] lo;
        logic [LW-1:0] hi;
    } range_t;

    function automatic range_t mk(input int lo, input int hi);
        range_t r;
        r.lo = LW'(lo);
        r.hi = LW'(hi);
        return r;
    endfunction

    range_t rng;

    always_comb begin
        rng = mk(4, 4);
        case (op)
            OP_ADD:  rng = mk(9, 10);
            OP_MUL:  rng = dbl ? mk(11, 17) : mk(10, 12);
            OP_MAC:  rng = dbl ? mk(19, 26) : mk(18, 21);
            OP_DIV:  rng = dbl ? mk(29, 65) : mk(20, 37);
            OP_SQRT: rng = dbl ? mk(29, 60) : mk(19, 33);
            OP_MOVE: rng = mk(4, 4);
            OP_CMP:  rng = mk(4, 7);
            OP_I2F:  rng = mk(9, 9);
            OP_F2I:  rng = mk(8, 8);
            OP_F2X:  rng = dbl ? mk(8, 8) : mk(6, 6);
            OP_S2D:  rng = mk(5, 5);
            OP_D2S:  rng = mk(7, 7);
            default: rng = mk(4, 4);
        endcase
    end

    assign lat_lo = rng.lo;
    assign lat_hi = rng.hi;

endmodule

// File: rtl/fpit_penalty.sv
module fpit_penalty
    import fpit_pkg::*;
#(
    parameter int LW = CNT_W
) (
    input  logic [3:0]        op,
    input  logic [N_OPND-1:0][1:0] cls_opnd,
    input  logic [1:0]        cls_mid,
    input  logic [1:0]        cls_res,
    input  logic              ftz,
    input  logic              fast,
    output logic              special_hit,
    output logic [LW-1:0]     pen
);

    logic [N_OPND-1:0] reads;
    logic              opnd_elig;
    logic              res_elig;
    logic              mid_elig;

    always_comb begin
        reads     = N_OPND'(3'b001);
        opnd_elig = 1'b0;
        res_elig  = 1'b0;
        mid_elig  = 1'b0;
        case (op)
            OP_ADD, OP_MUL, OP_DIV: begin
                reads     = N_OPND'(3'b011);
                opnd_elig = 1'b1;
                res_elig  = 1'b1;
            end
            OP_MAC: begin
                reads     = N_OPND'(3'b111);
                opnd_elig = 1'b1;
                res_elig  = 1'b1;
                mid_elig  = 1'b1;
            end
            OP_SQRT, OP_S2D: begin
                opnd_elig = 1'b1;
            end
            OP_CMP: begin
                reads = N_OPND'(3'b011);
            end
            OP_D2S: begin
                mid_elig = 1'b1;
            end
            default: ;
        endcase
    end

    localparam logic [LW-1:0] OPND_LO = LW'(PEN_OPND_LO);
    localparam logic [LW-1:0] OPND_HI = LW'(PEN_OPND_HI);
    localparam logic [LW-1:0] MID_LO  = LW'(PEN_MID_LO);
    localparam logic [LW-1:0] MID_HI  = LW'(PEN_MID_HI);
    localparam logic [LW-1:0] RES_LO  = LW'(PEN_RES_LO);
    localparam logic [LW-1:0] RES_HI  = LW'(PEN_RES_HI);

    logic [N_OPND-1:0][LW-1:0] opnd_pen;
    logic [N_OPND-1:0]         opnd_spec;

    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        always_comb begin
            opnd_spec[i] = reads[i] && is_special(cls_opnd[i]);
            opnd_pen[i]  = '0;
            if (reads[i] && opnd_elig && is_sub(cls_opnd[i]))
                opnd_pen[i] = fast ? OPND_LO : OPND_HI;
        end
    end

    logic [LW-1:0] mid_pen;
    logic [LW-1:0] res_pen;
    logic [LW-1:0] sum;

    always_comb begin
        mid_pen = '0;
        res_pen = '0;
        if (mid_elig && is_sub(cls_mid))
            mid_pen = fast ? MID_LO : MID_HI;
        if (res_elig && is_sub(cls_res))
            res_pen = fast ? RES_LO : RES_HI;
        sum = mid_pen + res_pen;
        for (int k = 0; k < N_OPND; k++)
            sum = sum + opnd_pen[k];
    end

    assign special_hit = |opnd_spec;
    assign pen         = (ftz || special_hit) ? '0 : sum;

endmodule

// File: rtl/fpit_seq.sv
module fpit_seq #(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] lat,
    output logic          busy,
    output logic          done,
    output logic [LW-1:0] lat_held
);

    typedef struct packed {
        logic          busy;
        logic [LW-1:0] cnt;
        logic [LW-1:0] lat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0)
                st_d.busy = 1'b0;
            else
                st_d.cnt = st_q.cnt - 1'b1;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = lat - 1'b1;
            st_d.lat  = lat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign done     = st_q.busy && (st_q.cnt == '0);
    assign lat_held = st_q.lat;

endmodule

// File: rtl/fpu_issue_timer.sv
module fpu_issue_timer
    import fpit_pkg::*;
#(
    parameter int LW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [3:0]    in_op,
    input  logic          in_dbl,
    input  logic [1:0]    in_cls_a,
    input  logic [1:0]    in_cls_b,
    input  logic [1:0]    in_cls_c,
    input  logic [1:0]    in_cls_mid,
    input  logic [1:0]    in_cls_res,
    input  logic          in_ftz,
    input  logic          in_fast,
    output logic          busy,
    output logic          done,
    output logic [LW-1:0] lat_out
);

    logic [LW-1:0]            base_lo, base_hi;
    logic [LW-1:0]            pen;
    logic                     special_hit;
    logic [N_OPND-1:0][1:0]   cls_vec;
    logic [LW-1:0]            lat_d;
    logic                     start;

    assign cls_vec = {in_cls_c, in_cls_b, in_cls_a};

    fpit_base_lat #(.LW(LW)) u_base (
        .op     (in_op),
        .dbl    (in_dbl),
        .lat_lo (base_lo),
        .lat_hi (base_hi)
    );

    fpit_penalty #(.LW(LW)) u_pen (
        .op          (in_op),
        .cls_opnd    (cls_vec),
        .cls_mid     (in_cls_mid),
        .cls_res     (in_cls_res),
        .ftz         (in_ftz),
        .fast        (in_fast),
        .special_hit (special_hit),
        .pen         (pen)
    );

    always_comb begin
        if (special_hit || in_fast)
            lat_d = base_lo + pen;
        else
            lat_d = base_hi + pen;
    end

    assign start = in_valid && in_ready;

    fpit_seq #(.LW(LW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .lat      (lat_d),
        .busy     (busy),
        .done     (done),
        .lat_held (lat_out)
    );

    assign in_ready = !busy;

endmodule

// File: rtl/fpit_chk.sv
module fpit_chk #(
    parameter int LW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_ftz,
    input logic          busy,
    input logic          done,
    input logic [LW-1:0] lat_out
);

    // R2
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R2
    busy_ends_by_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R3
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lat_out));

    // R12
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy && lat_out >= LW'(4));

    // R10
    ftz_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_ftz) |=> lat_out <= LW'(65));

endmodule

bind fpu_issue_timer fpit_chk #(.LW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_ftz   (in_ftz),
    .busy     (busy),
    .done     (done),
    .lat_out  (lat_out)
);

// File: tb/fpu_issue_timer_test.sv
module fpu_issue_timer_test;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] in_op = '0;
    logic       in_dbl = 1'b0;
    logic [1:0] in_cls_a = '0, in_cls_b = '0, in_cls_c = '0;
    logic [1:0] in_cls_mid = '0, in_cls_res = '0;
    logic       in_ftz = 1'b0, in_fast = 1'b0;
    logic       busy, done;
    logic [6:0] lat_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    fpu_issue_timer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_dbl(in_dbl), .in_cls_a(in_cls_a), .in_cls_b(in_cls_b),
        .in_cls_c(in_cls_c), .in_cls_mid(in_cls_mid), .in_cls_res(in_cls_res),
        .in_ftz(in_ftz), .in_fast(in_fast), .busy(busy), .done(done), .lat_out(lat_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic setd(input logic [3:0] op, input logic dbl,
                        input logic [1:0] a, input logic [1:0] b, input logic [1:0] c,
                        input logic [1:0] m, input logic [1:0] r,
                        input logic ftz, input logic fast);
        in_op = op; in_dbl = dbl; in_cls_a = a; in_cls_b = b; in_cls_c = c;
        in_cls_mid = m; in_cls_res = r; in_ftz = ftz; in_fast = fast;
    endtask

    // issue one descriptor and measure its busy window and done position
    task automatic run_op(input string tag,
                          input logic [3:0] op, input logic dbl,
                          input logic [1:0] a, input logic [1:0] b, input logic [1:0] c,
                          input logic [1:0] m, input logic [1:0] r,
                          input logic ftz, input logic fast, input int exp);
        int n = 0;
        int dcnt = 0;
        int dpos = 0;
        while (!in_ready) @(negedge clk);
        setd(op, dbl, a, b, c, m, r, ftz, fast);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(lat_out == 7'(exp), {tag, " lat_out (R12)"}, lat_out, exp);
        while (busy && n < 200) begin
            n++;
            chk(!in_ready, {tag, " ready low while busy (R1)"}, in_ready, 0);
            if (done) begin dcnt++; dpos = n; end
            @(negedge clk);
        end
        chk(n == exp, {tag, " busy cycles (R2)"}, n, exp);
        chk(dcnt == 1 && dpos == n, {tag, " done on last cycle (R2)"}, dpos, n);
        chk(in_ready && !done, {tag, " ready after done (R2)"}, in_ready, 1);
    endtask

    task automatic t_reset();
        chk(!busy && !done && in_ready && lat_out == 0, "R1 reset state",
            {busy, done, in_ready}, 3'b001);
    endtask

    task automatic t_add();
        run_op("R4 add single slow", 4'd0, 0, 0, 0, 0, 0, 0, 0, 0, 10);
        run_op("R4 add single fast", 4'd0, 0, 0, 0, 0, 0, 0, 0, 1, 9);
        run_op("R4 add double slow", 4'd0, 1, 0, 0, 0, 0, 0, 0, 0, 10);
    endtask

    task automatic t_long_ops();
        run_op("R5 mul s fast", 4'd1, 0, 0, 0, 0, 0, 0, 0, 1, 10);
        run_op("R5 mul s slow", 4'd1, 0, 0, 0, 0, 0, 0, 0, 0, 12);
        run_op("R5 mul d fast", 4'd1, 1, 0, 0, 0, 0, 0, 0, 1, 11);
        run_op("R5 mul d slow", 4'd1, 1, 0, 0, 0, 0, 0, 0, 0, 17);
        run_op("R5 mac d slow", 4'd2, 1, 0, 0, 0, 0, 0, 0, 0, 26);
        run_op("R5 mac s fast", 4'd2, 0, 0, 0, 0, 0, 0, 0, 1, 18);
        run_op("R5 div s fast", 4'd3, 0, 0, 0, 0, 0, 0, 0, 1, 20);
        run_op("R5 div d slow", 4'd3, 1, 0, 0, 0, 0, 0, 0, 0, 65);
        run_op("R5 sqrt d fast", 4'd4, 1, 0, 0, 0, 0, 0, 0, 1, 29);
        run_op("R5 sqrt s slow", 4'd4, 0, 0, 0, 0, 0, 0, 0, 0, 33);
    endtask

    task automatic t_short_ops();
        run_op("R6 move", 4'd5, 1, 0, 0, 0, 0, 0, 0, 0, 4);
        run_op("R6 cmp fast", 4'd6, 0, 0, 0, 0, 0, 0, 0, 1, 4);
        run_op("R6 cmp slow", 4'd6, 1, 0, 0, 0, 0, 0, 0, 0, 7);
        run_op("R6 int to float", 4'd7, 0, 0, 0, 0, 0, 0, 0, 0, 9);
        run_op("R6 float to int", 4'd8, 1, 0, 0, 0, 0, 0, 0, 0, 8);
        run_op("R6 to fixed s", 4'd9, 0, 0, 0, 0, 0, 0, 0, 0, 6);
        run_op("R6 to fixed d", 4'd9, 1, 0, 0, 0, 0, 0, 0, 0, 8);
        run_op("R6 s to d", 4'd10, 0, 0, 0, 0, 0, 0, 0, 0, 5);
        run_op("R6 d to s", 4'd11, 1, 0, 0, 0, 0, 0, 0, 0, 7);
        run_op("R6 reserved code", 4'd14, 0, 0, 0, 0, 0, 0, 0, 0, 4);
    endtask

    task automatic t_penalties();
        run_op("R7 add a sub slow", 4'd0, 0, 1, 0, 0, 0, 0, 0, 0, 20);
        run_op("R7 add a,b sub fast", 4'd0, 0, 1, 1, 0, 0, 0, 0, 1, 27);
        run_op("R7 R8 mul b sub res sub", 4'd1, 1, 0, 1, 0, 0, 1, 0, 0, 34);
        run_op("R7 sqrt unread b sub", 4'd4, 0, 0, 1, 1, 0, 0, 0, 0, 33);
        run_op("R7 s to d a sub", 4'd10, 0, 1, 0, 0, 0, 0, 0, 0, 15);
        run_op("R7 float to int a sub", 4'd8, 0, 1, 1, 0, 0, 1, 0, 0, 8);
        run_op("R8 div res sub fast", 4'd3, 0, 0, 0, 0, 0, 1, 0, 1, 26);
        run_op("R8 cmp res sub ignored", 4'd6, 0, 0, 0, 0, 1, 1, 0, 0, 7);
        run_op("R9 mac mid sub slow", 4'd2, 0, 0, 0, 0, 1, 0, 0, 0, 34);
        run_op("R9 mac all sub fast", 4'd2, 0, 1, 1, 1, 1, 1, 0, 1, 62);
        run_op("R9 d to s mid fast", 4'd11, 1, 0, 0, 0, 1, 0, 0, 1, 18);
        run_op("R9 d to s mid slow", 4'd11, 1, 0, 0, 0, 1, 0, 0, 0, 20);
        run_op("R9 add mid ignored", 4'd0, 0, 0, 0, 0, 1, 0, 0, 0, 10);
        run_op("R7 div d worst", 4'd3, 1, 1, 1, 0, 0, 1, 0, 0, 92);
    endtask

    task automatic t_ftz();
        run_op("R10 mac all sub ftz", 4'd2, 0, 1, 1, 1, 1, 1, 1, 0, 21);
        run_op("R10 div d sub ftz", 4'd3, 1, 1, 0, 0, 0, 1, 1, 0, 65);
        run_op("R10 d to s ftz", 4'd11, 1, 0, 0, 0, 1, 0, 1, 0, 7);
    endtask

    task automatic t_special();
        run_op("R11 div d a special", 4'd3, 1, 2, 1, 0, 0, 1, 0, 0, 29);
        run_op("R11 mul s b special", 4'd1, 0, 0, 3, 0, 0, 1, 0, 0, 10);
        run_op("R11 cmp a special", 4'd6, 0, 2, 0, 0, 0, 0, 0, 0, 4);
        run_op("R11 mac d c special", 4'd2, 1, 1, 0, 2, 1, 0, 0, 0, 19);
        run_op("R11 sqrt unread b special", 4'd4, 0, 0, 2, 0, 0, 0, 0, 0, 33);
    endtask

    task automatic t_stall();
        int n = 0;
        int seen = 0;
        while (!in_ready) @(negedge clk);
        setd(4'd1, 0, 0, 0, 0, 0, 0, 0, 0);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // present a conflicting short descriptor the whole time
        setd(4'd5, 0, 0, 0, 0, 0, 0, 0, 1);
        while (busy && n < 200) begin
            n++;
            if (lat_out != 7'd12) seen++;
            if (done) in_valid = 1'b0;
            @(negedge clk);
        end
        chk(seen == 0, "R3 lat_out stable while busy", seen, 0);
        chk(n == 12, "R3 busy length unchanged", n, 12);
        repeat (5) @(negedge clk);
        chk(!busy && in_ready && lat_out == 7'd12, "R3 nothing queued",
            {busy, lat_out}, 12);
        run_op("R3 back to back after stall", 4'd6, 0, 0, 0, 0, 0, 0, 0, 1, 4);
        run_op("R2 back to back next", 4'd7, 0, 0, 0, 0, 0, 0, 0, 0, 9);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_long_ops();
        t_short_ops();
        t_penalties();
        t_ftz();
        t_special();
        t_stall();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule